// File: doc/BRIEF.md
# Exception Spawn Predictor

This block decides, for each class of recoverable exception, whether the exception should be given to a spare hardware thread context or handled by the conventional flush-and-refetch path. Exception types are identified by a 4-bit code. Each type owns a saturating confidence counter, and a combinational lookup returns a one-bit spawn decision for the type presented on the lookup port.

The counters learn from completed spawned handlers. A handler that finished with a normal return from exception moves its type's counter one step toward spawning. A handler that gave up by issuing the hard-exception instruction, which means the full conventional path was needed, moves it one step toward not spawning. Software can also take direct control of any type through a pair of per-type configuration registers. The enable register selects which types are overridden, and the value register gives the decision for each overridden type. Overridden types keep training in the background, so their learned state is ready when the override is lifted.

Each counter is a small state machine. Its action each cycle is one of three named transitions. HOLD keeps the state. UP adds one and stays at the top when already saturated. DOWN subtracts one and stays at zero when already there. The counter's state value runs from zero up to the all-ones value. Every counter resets to the weak-spawn state, in which only the most significant bit is set.

Top module: `spawn_predictor`

## Requirements
- R1: After reset every type predicts spawn (spawn_o = 1), and no override is enabled.
- R2: An update with upd_hard_i = 1 (handler ended with the hard-exception instruction) takes the DOWN transition on that type's counter, which stays at zero once there.
- R3: An update with upd_hard_i = 0 (normal return from exception) takes the UP transition, which stays at the all-ones value once there.
- R4: With no override for the looked-up type, spawn_o equals the most significant bit of that type's counter. With the default 2-bit counter, state 2 or 3 means spawn and state 0 or 1 means no spawn.
- R5: When bit t of the override-enable register is 1, a lookup of type t returns bit t of the override-value register, whatever the counter holds.
- R6: Updates to an overridden type still train its counter, so the trained state decides the prediction once the override is cleared.
- R7: A lookup and an update of the same type in the same cycle return the prediction from before the update. The new state is seen from the next cycle.
- R8: An update changes only the counter of its own type. A cycle with upd_valid_i = 0 changes no counter, whatever the other update inputs are.
- R9: cfg_wr_i = 1 loads cfg_en_i and cfg_val_i into the two override registers together. The new setting decides lookups from the next cycle, and lookups in the write cycle still see the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_type_i | input | 4 | Exception type to look up |
| spawn_o | output | 1 | 1 = spawn a helper thread for the looked-up type |
| upd_valid_i | input | 1 | A spawned handler finished this cycle |
| upd_type_i | input | 4 | Type of the finished handler |
| upd_hard_i | input | 1 | 1 = handler issued hard-exception instruction, 0 = normal return |
| cfg_wr_i | input | 1 | Write both override registers |
| cfg_en_i | input | 16 | New override-enable mask, one bit per type |
| cfg_val_i | input | 16 | New override decision, one bit per type |

## Verification
Directed sequences walk a single type through every counter state, with repeated hard aborts into the floor and repeated normal returns into the ceiling. The decision seen after the step back from each end shows whether the counter saturated or wrapped. Untouched types and cycles with the valid bit low, but with the other update inputs set, show whether training leaks into other entries. Lookups that coincide with an update or a configuration write of the same type show whether the decision comes from before or after the edge. An override applied while its type trains shows both that the mask wins and that the hidden counter kept learning. A long seeded random mix of updates, lookups and occasional configuration writes, checked against a reference model, covers the combinations that the directed cases do not reach.

// File: rtl/spn_pkg.sv
package spn_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_UP   = 2'd1,
        ACT_DOWN = 2'd2
    } ctr_act_e;
endpackage

// File: rtl/spn_ctr.sv
module spn_ctr
    import spn_pkg::*;
#(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctr_act_e      act_i,
    output logic [CW-1:0] state_o
);
    localparam logic [CW-1:0] ST_WEAK = {1'b1, {(CW-1){1'b0}}};
    localparam logic [CW-1:0] ST_TOP  = '1;
    localparam logic [CW-1:0] ST_BOT  = '0;
    localparam logic [CW-1:0] STEP    = 1;

    logic [CW-1:0] state_q;
    logic [CW-1:0] state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WEAK;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (act_i)
            ACT_HOLD: state_d = state_q;
            ACT_UP:   if (state_q != ST_TOP) state_d = state_q + STEP;
            ACT_DOWN: if (state_q != ST_BOT) state_d = state_q - STEP;
            default:  state_d = state_q;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/spn_ovr_reg.sv
module spn_ovr_reg #(
    parameter int NT = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [NT-1:0] en_i,
    input  logic [NT-1:0] val_i,
    output logic [NT-1:0] en_o,
    output logic [NT-1:0] val_o
);
    logic [NT-1:0] en_q;
    logic [NT-1:0] val_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            val_q <= '0;
        end else if (wr_i) begin
            en_q  <= en_i;
            val_q <= val_i;
        end
    end

    assign en_o  = en_q;
    assign val_o = val_q;
endmodule

// File: rtl/spawn_predictor.sv
module spawn_predictor
    import spn_pkg::*;
#(
    parameter int NT = 16,
    parameter int CW = 2,
    localparam int TW = $clog2(NT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] lk_type_i,
    output logic          spawn_o,
    input  logic          upd_valid_i,
    input  logic [TW-1:0] upd_type_i,
    input  logic          upd_hard_i,
    input  logic          cfg_wr_i,
    input  logic [NT-1:0] cfg_en_i,
    input  logic [NT-1:0] cfg_val_i
);
    logic [NT*CW-1:0] ctr_flat;
    logic [NT-1:0]    ovr_en;
    logic [NT-1:0]    ovr_val;
    ctr_act_e         act [NT];

    spn_ovr_reg #(.NT(NT)) u_ovr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (cfg_wr_i),
        .en_i  (cfg_en_i),
        .val_i (cfg_val_i),
        .en_o  (ovr_en),
        .val_o (ovr_val)
    );

    for (genvar t = 0; t < NT; t++) begin : g_ent
        always_comb begin
            if (upd_valid_i && (upd_type_i == TW'(t)))
                act[t] = upd_hard_i ? ACT_DOWN : ACT_UP;
            else
                act[t] = ACT_HOLD;
        end

        spn_ctr #(.CW(CW)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .act_i   (act[t]),
            .state_o (ctr_flat[t*CW +: CW])
        );
    end

    logic [CW-1:0] lk_state;

    always_comb begin
        lk_state = ctr_flat[lk_type_i*CW +: CW];
        if (ovr_en[lk_type_i]) spawn_o = ovr_val[lk_type_i];
        else                   spawn_o = lk_state[CW-1];
    end
endmodule

// File: rtl/spawn_predictor_chk.sv
module spawn_predictor_chk #(
    parameter int NT = 16,
    parameter int CW = 2,
    localparam int TW = $clog2(NT)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TW-1:0]    lk_type_i,
    input logic             spawn_o,
    input logic             upd_valid_i,
    input logic [TW-1:0]    upd_type_i,
    input logic             upd_hard_i,
    input logic             cfg_wr_i,
    input logic [NT-1:0]    cfg_en_i,
    input logic [NT-1:0]    cfg_val_i,
    input logic [NT*CW-1:0] ctr_flat,
    input logic [NT-1:0]    ovr_en,
    input logic [NT-1:0]    ovr_val
);
    localparam logic [CW-1:0] ONE  = 1;
    localparam logic [CW-1:0] TOPV = '1;

    function automatic logic [CW-1:0] getc(input logic [NT*CW-1:0] f, input logic [TW-1:0] t);
        return f[t*CW +: CW];
    endfunction

    logic [CW-1:0] upd_c;
    assign upd_c = getc(ctr_flat, upd_type_i);

    // R2: hard abort steps down, floor at zero
    p_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid_i && upd_hard_i) |=>
        (getc(ctr_flat, $past(upd_type_i)) ==
         (($past(upd_c) == '0) ? '0 : ($past(upd_c) - ONE))));

    // R3: normal return steps up, ceiling at all-ones
    p_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid_i && !upd_hard_i) |=>
        (getc(ctr_flat, $past(upd_type_i)) ==
         (($past(upd_c) == TOPV) ? TOPV : ($past(upd_c) + ONE))));

    // R8: no update, no counter movement
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid_i |=> $stable(ctr_flat));

    // R9: configuration write loads both registers
    p_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_i |=> (ovr_en == $past(cfg_en_i)) && (ovr_val == $past(cfg_val_i)));

    // R9: without a write the override registers hold
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_i |=> $stable(ovr_en) && $stable(ovr_val));

    // R5: enabled override decides the output
    p_ovr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_en[lk_type_i] |-> (spawn_o == ovr_val[lk_type_i]));

    // R4: without override the counter MSB decides
    p_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr_en[lk_type_i] |-> (spawn_o == getc(ctr_flat, lk_type_i)[CW-1]));
endmodule

bind spawn_predictor spawn_predictor_chk #(.NT(NT), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_type_i   (lk_type_i),
    .spawn_o     (spawn_o),
    .upd_valid_i (upd_valid_i),
    .upd_type_i  (upd_type_i),
    .upd_hard_i  (upd_hard_i),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_en_i    (cfg_en_i),
    .cfg_val_i   (cfg_val_i),
    .ctr_flat    (ctr_flat),
    .ovr_en      (ovr_en),
    .ovr_val     (ovr_val)
);

// File: tb/tb_spawn_predictor.sv
`timescale 1ns/1ps
module tb_spawn_predictor;
    localparam int NT = 16;
    localparam int CW = 2;
    localparam int TW = 4;
    localparam int TOPV = (1 << CW) - 1;
    localparam int WEAK = 1 << (CW - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] lk_type_i = '0;
    logic          spawn_o;
    logic          upd_valid_i = 1'b0;
    logic [TW-1:0] upd_type_i = '0;
    logic          upd_hard_i = 1'b0;
    logic          cfg_wr_i = 1'b0;
    logic [NT-1:0] cfg_en_i = '0;
    logic [NT-1:0] cfg_val_i = '0;

    always #2.5 clk = ~clk;

    spawn_predictor #(.NT(NT), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .lk_type_i(lk_type_i), .spawn_o(spawn_o),
        .upd_valid_i(upd_valid_i), .upd_type_i(upd_type_i), .upd_hard_i(upd_hard_i),
        .cfg_wr_i(cfg_wr_i), .cfg_en_i(cfg_en_i), .cfg_val_i(cfg_val_i)
    );

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    int  mc [NT];
    bit  men [NT];
    bit  mval [NT];

    function automatic bit exp_spawn(input int t);
        if (men[t]) return mval[t];
        return (mc[t] >= WEAK);
    endfunction

    task automatic check(input string tag, input bit got, input bit exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: spawn_o=%0b expected=%0b", tag, got, exp);
        end
    endtask

    // Drive one cycle (called just after a falling edge), check before the
    // rising edge, then advance the reference model.
    task automatic step(input bit uv, input int ut, input bit uh, input int lt,
                        input bit cw, input logic [NT-1:0] ce, input logic [NT-1:0] cv,
                        input string tag);
        upd_valid_i = uv; upd_type_i = TW'(ut); upd_hard_i = uh;
        lk_type_i = TW'(lt);
        cfg_wr_i = cw; cfg_en_i = ce; cfg_val_i = cv;
        #1;
        check(tag, spawn_o, exp_spawn(lt));
        @(posedge clk);
        if (uv) begin
            if (uh) begin if (mc[ut] > 0) mc[ut]--; end
            else    begin if (mc[ut] < TOPV) mc[ut]++; end
        end
        if (cw) for (int t = 0; t < NT; t++) begin men[t] = ce[t]; mval[t] = cv[t]; end
        @(negedge clk);
    endtask

    task automatic look(input int lt, input string tag);
        step(1'b0, 0, 1'b0, lt, 1'b0, '0, '0, tag);
    endtask

    task automatic upd(input int ut, input bit uh, input string tag);
        step(1'b1, ut, uh, ut, 1'b0, '0, '0, tag);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: spawn_o=%0b expected=completion", spawn_o);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < NT; t++) begin mc[t] = WEAK; men[t] = 0; mval[t] = 0; end
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, all types spawn
        for (int t = 0; t < NT; t++) look(t, "R1 reset spawn");

        // R2 / R4: type 3 trained down into the floor
        upd(3, 1'b1, "R4 pre-update weak");
        look(3, "R4 state1 no spawn");
        upd(3, 1'b1, "R2 down to zero");
        upd(3, 1'b1, "R2 floor hold");
        upd(3, 1'b0, "R2 from floor");
        look(3, "R2 floor did not wrap");
        // R3: climb into the ceiling
        upd(3, 1'b0, "R3 up");
        look(3, "R4 state2 spawn");
        upd(3, 1'b0, "R3 up to top");
        upd(3, 1'b0, "R3 ceiling hold");
        upd(3, 1'b1, "R3 step back");
        look(3, "R3 ceiling did not wrap");

        // R8: other types untouched; valid low ignored
        look(5, "R8 neighbour untouched");
        for (int i = 0; i < 4; i++) step(1'b0, 4, 1'b1, 4, 1'b0, '0, '0, "R8 invalid update");
        look(4, "R8 invalid update ignored");

        // R9 / R5: override type 7 to no-spawn
        step(1'b0, 0, 1'b0, 7, 1'b1, 16'h0080, 16'h0000, "R9 old setting in write cycle");
        look(7, "R5 override no spawn");
        look(6, "R5 other type not overridden");
        // R6: train while overridden, then release
        upd(7, 1'b1, "R6 train under override");
        upd(7, 1'b1, "R6 train under override");
        look(7, "R5 override still wins");
        step(1'b0, 0, 1'b0, 7, 1'b1, 16'h0000, 16'h0000, "R9 release write cycle");
        look(7, "R6 trained state shows");
        // R5: override forcing spawn on a no-spawn counter
        step(1'b0, 0, 1'b0, 7, 1'b1, 16'h0080, 16'h0080, "R9 force-spawn write");
        look(7, "R5 override forces spawn");
        step(1'b0, 0, 1'b0, 7, 1'b1, 16'h0000, 16'h0000, "R9 clear");

        // R7: same-cycle lookup and update
        step(1'b1, 9, 1'b1, 9, 1'b0, '0, '0, "R7 pre-update prediction");
        look(9, "R7 update visible next cycle");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            bit uv, uh, cw;
            int ut, lt;
            logic [NT-1:0] ce, cv;
            string tag;
            uv = ($urandom % 4) != 0;
            uh = $urandom % 2;
            ut = $urandom % NT;
            lt = (($urandom % 3) == 0) ? ut : ($urandom % NT);
            cw = ($urandom % 40) == 0;
            ce = NT'($urandom) & NT'($urandom);
            cv = NT'($urandom);
            if (men[lt])           tag = "R5 random override";
            else if (uv && ut == lt) tag = "R7 random same-type";
            else                   tag = "R4 random";
            step(uv, ut, uh, lt, cw, ce, cv, tag);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule